// File: doc/BRIEF.md
# Depth-Chained FIFO Slice

This block is one slice of a FIFO that is made deeper by chaining several identical slices in a ring. Each slice keeps a small local store with its own write and read pointers. All slices see the same write strobe, write data and read strobe. Two tokens decide which slice acts on them: a write token and a read token. Only the slice that holds the write token stores a word. Only the slice that holds the read token presents and pops a word.

When the owning slice fills its last local location, it drives its chain output low and so hands the write token to its neighbour. Emptying that last location hands the read token on in the same way. The chain output of the final slice loops back to the first slice. The first-load input picks the slice that holds both tokens after reset. A slice without the read token drives zeros on its data output, so the read data of the whole chain is the OR of all slices' outputs. Each slice also reports local empty and full flags. Combining those flags across the chain is left to the surrounding logic.

The chain pulse is combinational with the strobe that causes it. The token therefore leaves one slice and arrives at the next on the same clock edge, and no strobe falls into a gap where nobody owns the token.

Top module: `fifo_chain_slice`

## Requirements
- R1: While `rstN` is low on a clock edge, a slice whose `firstLoadN` is 0 takes both tokens, and every other slice takes neither. Every slice becomes locally empty (`emptyN`=0, `fullN`=1), expects a write handoff first, and shows `chainOut`=1 and `rdData`=0.
- R2: A write strobe stores `wrData` only in the slice that holds the write token, and only if that slice holds fewer than DEPTH words. All other slices ignore it.
- R3: A write accepted into local index DEPTH-1 drives `chainOut` low during that same cycle. At that edge the slice drops its write token and wraps its write pointer to 0.
- R4: A read accepted from local index DEPTH-1 drives `chainOut` low during that same cycle. At that edge the slice drops its read token and wraps its read pointer to 0.
- R5: A low `chainIn` on a clock edge grants the write token if the slice expects a write handoff, and otherwise grants the read token. Each received pulse toggles that expectation.
- R6: Across a ring of slices, exactly one slice shows `wrOwn`=1 and exactly one shows `rdOwn`=1 at all times.
- R7: `rdData` shows the oldest local word when the slice holds the read token and is not locally empty. Otherwise `rdData` is all zeros.
- R8: A read strobe pops a word only at the slice that holds the read token, and only when that slice is not locally empty. A read on an empty chain changes nothing.
- R9: Words leave the chain in the order they were accepted, including across slice boundaries and around the ring.
- R10: A write strobe at a write owner that is locally full is dropped. The slice keeps the token and stays full.
- R11: `emptyN` is 0 exactly when the slice holds no words. `fullN` is 0 exactly when it holds DEPTH words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| firstLoadN | input | 1 | Low on the slice that owns both tokens after reset |
| chainIn | input | 1 | Token handoff from the previous slice, active low |
| chainOut | output | 1 | Token handoff to the next slice, active low, one cycle |
| wrStb | input | 1 | Write strobe shared by all slices |
| wrData | input | WIDTH | Write data shared by all slices |
| rdStb | input | 1 | Read strobe shared by all slices |
| rdData | output | WIDTH | Oldest local word, or zeros when not enabled |
| wrOwn | output | 1 | Slice holds the write token |
| rdOwn | output | 1 | Slice holds the read token (output enable) |
| emptyN | output | 1 | Low when the slice holds no words |
| fullN | output | 1 | Low when the slice holds DEPTH words |

## Verification
The handoff pulse on `chainOut` is combinational, so it is due in the same cycle as the strobe that causes it. The bench samples it 1 ns after driving the inputs on the falling edge. Token ownership, `rdData` and both flags change only at the next rising edge. The bench checks them 1 ns after the following falling edge, against a model that it has already advanced by one step. The model predicts the owners from the counts of accepted writes and reads divided by the local depth. It decides acceptance from the chain-wide occupancy before each edge.

// File: rtl/fifo_chain_pkg.sv
package fifo_chain_pkg;
  // Strobes from the token control to the local store.
  typedef struct packed {
    logic push;
    logic pop;
  } slice_strobe_t;
endpackage

// File: rtl/fifo_chain_store.sv
module fifo_chain_store
  import fifo_chain_pkg::*;
#(
  parameter int WIDTH = 9,
  parameter int DEPTH = 512
) (
  input  logic             clk,
  input  logic             rstN,
  input  slice_strobe_t    strobe,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] headWord,
  output logic             wrAtLast,
  output logic             rdAtLast
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;

  assign wrAtLast = (wrPtr == LAST_IDX);
  assign rdAtLast = (rdPtr == LAST_IDX);
  assign headWord = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (strobe.push) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobe.push) wrPtr <= wrAtLast ? '0 : wrPtr + PTR_W'(1);
      if (strobe.pop)  rdPtr <= rdAtLast ? '0 : rdPtr + PTR_W'(1);
    end
  end
endmodule

// File: rtl/fifo_chain_ctrl.sv
module fifo_chain_ctrl
  import fifo_chain_pkg::*;
#(
  parameter int DEPTH = 512
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          firstLoadN,
  input  logic          chainIn,
  input  logic          wrStb,
  input  logic          rdStb,
  input  logic          wrAtLast,
  input  logic          rdAtLast,
  output slice_strobe_t strobe,
  output logic          chainOut,
  output logic          wrOwn,
  output logic          rdOwn,
  output logic          expectWr,
  output logic          emptyN,
  output logic          fullN
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [CNT_W-1:0] count;
  logic localEmpty, localFull;
  logic wrPass, rdPass, inPulse;

  assign localEmpty = (count == '0);
  assign localFull  = (count == FULL_CNT);
  assign emptyN     = ~localEmpty;
  assign fullN      = ~localFull;

  assign strobe.push = wrStb & wrOwn & ~localFull;
  assign strobe.pop  = rdStb & rdOwn & ~localEmpty;

  assign wrPass   = strobe.push & wrAtLast;
  assign rdPass   = strobe.pop & rdAtLast;
  assign chainOut = ~(wrPass | rdPass);
  assign inPulse  = ~chainIn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrOwn    <= ~firstLoadN;
      rdOwn    <= ~firstLoadN;
      expectWr <= 1'b1;
      count    <= '0;
    end else begin
      wrOwn <= (wrOwn & ~wrPass) | (inPulse & expectWr);
      rdOwn <= (rdOwn & ~rdPass) | (inPulse & ~expectWr);
      if (inPulse) expectWr <= ~expectWr;
      case ({strobe.push, strobe.pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/fifo_chain_slice.sv
module fifo_chain_slice
  import fifo_chain_pkg::*;
#(
  parameter int WIDTH = 9,
  parameter int DEPTH = 512
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             firstLoadN,
  input  logic             chainIn,
  output logic             chainOut,
  input  logic             wrStb,
  input  logic [WIDTH-1:0] wrData,
  input  logic             rdStb,
  output logic [WIDTH-1:0] rdData,
  output logic             wrOwn,
  output logic             rdOwn,
  output logic             emptyN,
  output logic             fullN
);
  slice_strobe_t    strobe;
  logic             wrAtLast, rdAtLast, expectWr;
  logic [WIDTH-1:0] headWord;

  fifo_chain_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .firstLoadN(firstLoadN), .chainIn(chainIn),
    .wrStb(wrStb), .rdStb(rdStb), .wrAtLast(wrAtLast), .rdAtLast(rdAtLast),
    .strobe(strobe), .chainOut(chainOut), .wrOwn(wrOwn), .rdOwn(rdOwn),
    .expectWr(expectWr), .emptyN(emptyN), .fullN(fullN)
  );

  fifo_chain_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .headWord(headWord), .wrAtLast(wrAtLast), .rdAtLast(rdAtLast)
  );

  assign rdData = (rdOwn & emptyN) ? headWord : '0;
endmodule

// File: rtl/fifo_chain_slice_chk.sv
module fifo_chain_slice_chk (
  input logic clk,
  input logic rstN,
  input logic wrStb,
  input logic rdStb,
  input logic chainIn,
  input logic chainOut,
  input logic wrOwn,
  input logic rdOwn,
  input logic emptyN,
  input logic fullN,
  input logic wrAtLast,
  input logic rdAtLast,
  input logic expectWr
);
  assert_wr_handoff_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb && wrOwn && fullN && wrAtLast && chainIn) |=> !wrOwn);

  assert_rd_handoff_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rdStb && rdOwn && emptyN && rdAtLast && chainIn) |=> !rdOwn);

  assert_pulse_cause_R3: assert property (@(posedge clk) disable iff (!rstN)
    !chainOut |-> (wrStb || rdStb));

  assert_gain_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!chainIn && expectWr) |=> (wrOwn && !expectWr));

  assert_gain_read_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!chainIn && !expectWr) |=> (rdOwn && expectWr));

  assert_full_drop_R10: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb && !fullN && !rdStb) |=> !fullN);

  assert_empty_read_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rdStb && !emptyN && !wrStb) |=> !emptyN);

  assert_flags_excl_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(!emptyN && !fullN));
endmodule

bind fifo_chain_slice fifo_chain_slice_chk u_chk (
  .clk(clk), .rstN(rstN), .wrStb(wrStb), .rdStb(rdStb),
  .chainIn(chainIn), .chainOut(chainOut), .wrOwn(wrOwn), .rdOwn(rdOwn),
  .emptyN(emptyN), .fullN(fullN), .wrAtLast(wrAtLast), .rdAtLast(rdAtLast),
  .expectWr(expectWr)
);

// File: tb/sim_fifo_chain_slice.sv
module sim_fifo_chain_slice;
  localparam int W = 8;
  localparam int D = 4;
  localparam int N = 3;
  localparam int CAP = D * N;
  localparam int NV = 10;
  // {write, read, repeat count}
  localparam logic [9:0] VEC [NV] = '{
    {1'b0, 1'b1, 8'd2},  // reads on empty chain (R8)
    {1'b1, 1'b0, 8'd5},  // cross first boundary (R3)
    {1'b0, 1'b1, 8'd3},
    {1'b1, 1'b1, 8'd9},  // concurrent traffic (R9)
    {1'b1, 1'b0, 8'd14}, // fill and overflow (R10)
    {1'b1, 1'b1, 8'd3},  // both strobes while full
    {1'b0, 1'b1, 8'd14}, // drain past empty (R4, R8)
    {1'b1, 1'b1, 8'd2},  // both strobes while empty
    {1'b1, 1'b0, 8'd7},
    {1'b0, 1'b1, 8'd8}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrStb = 1'b0;
  logic rdStb = 1'b0;
  logic [W-1:0] wrData = '0;
  logic [N-1:0] chainV, wrOwnV, rdOwnV, emptyNV, fullNV;
  logic [W-1:0] rdDataV [N];
  logic [W-1:0] rdAll;

  always #10 clk = ~clk;

  for (genvar i = 0; i < N; i++) begin : g_slice
    fifo_chain_slice #(.WIDTH(W), .DEPTH(D)) u0 (
      .clk(clk), .rstN(rstN), .firstLoadN(i != 0),
      .chainIn(chainV[(i + N - 1) % N]), .chainOut(chainV[i]),
      .wrStb(wrStb), .wrData(wrData), .rdStb(rdStb), .rdData(rdDataV[i]),
      .wrOwn(wrOwnV[i]), .rdOwn(rdOwnV[i]), .emptyN(emptyNV[i]), .fullN(fullNV[i])
    );
  end

  always_comb begin
    rdAll = '0;
    for (int i = 0; i < N; i++) rdAll = rdAll | rdDataV[i];
  end

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;
  logic [W-1:0] q [CAP];
  int qHead = 0, total = 0, wCnt = 0, rCnt = 0;
  int sliceCnt [N];
  logic [W-1:0] dataCtr = 8'h10;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic checkState();
    logic [N-1:0] expEmptyN, expFullN;
    for (int i = 0; i < N; i++) begin
      expEmptyN[i] = (sliceCnt[i] != 0);
      expFullN[i]  = (sliceCnt[i] != D);
    end
    check("R6 write owner", 32'(wrOwnV), 32'(1 << ((wCnt / D) % N)));
    check("R6 read owner", 32'(rdOwnV), 32'(1 << ((rCnt / D) % N)));
    check("R9 R7 head data", 32'(rdAll), (total > 0) ? 32'(q[qHead]) : 32'h0);
    check("R11 R2 emptyN", 32'(emptyNV), 32'(expEmptyN));
    check("R11 R10 fullN", 32'(fullNV), 32'(expFullN));
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; wrStb = 1'b0; rdStb = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    qHead = 0; total = 0; wCnt = 0; rCnt = 0;
    for (int i = 0; i < N; i++) sliceCnt[i] = 0;
    #1;
    check("R1 write token", 32'(wrOwnV), 32'h1);
    check("R1 read token", 32'(rdOwnV), 32'h1);
    check("R1 empty", 32'(emptyNV), 32'h0);
    check("R1 not full", 32'(fullNV), 32'h7);
    check("R1 chain idle", 32'(chainV), 32'h7);
    check("R1 data zero", 32'(rdAll), 32'h0);
  endtask

  task automatic step(logic wr, logic rd);
    logic accW, accR;
    logic [N-1:0] expChain;
    int wIdx, rIdx;
    @(negedge clk);
    #1;
    checkState();
    wrStb = wr; rdStb = rd; wrData = dataCtr;
    #1;
    accW = wr && (total < CAP);
    accR = rd && (total > 0);
    wIdx = (wCnt / D) % N;
    rIdx = (rCnt / D) % N;
    expChain = '1;
    if (accW && (wCnt % D == D - 1)) expChain[wIdx] = 1'b0;
    if (accR && (rCnt % D == D - 1)) expChain[rIdx] = 1'b0;
    check("R3 R4 R5 chain pulse", 32'(chainV), 32'(expChain));
    if (accR) begin
      qHead = (qHead + 1) % CAP; total--; rCnt++; sliceCnt[rIdx]--;
    end
    if (accW) begin
      q[(qHead + total) % CAP] = dataCtr; total++; wCnt++; sliceCnt[wIdx]++;
    end
    if (wr) dataCtr = dataCtr + 8'd1;
    @(negedge clk);
    wrStb = 1'b0; rdStb = 1'b0;
  endtask

  initial begin
    doReset();
    for (int v = 0; v < NV; v++) begin
      for (int k = 0; k < int'(VEC[v][7:0]); k++) step(VEC[v][9], VEC[v][8]);
    end
    @(negedge clk);
    #1;
    checkState();
    // Directed: reset mid-traffic restores the start state (R1)
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    doReset();
    // Directed: read strobe on an empty chain is ignored (R8)
    step(1'b0, 1'b1);
    @(negedge clk);
    #1;
    check("R8 no pop on empty", 32'(emptyNV), 32'h0);
    check("R8 read token kept", 32'(rdOwnV), 32'h1);
    // Directed: exactly D writes move the write token only (R3, R5)
    for (int k = 0; k < D; k++) step(1'b1, 1'b0);
    @(negedge clk);
    #1;
    check("R3 token moved", 32'(wrOwnV), 32'h2);
    check("R5 read stays", 32'(rdOwnV), 32'h1);
    check("R11 slice0 full", 32'(fullNV), 32'h6);
    checkState();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end
endmodule